// File: doc/BRIEF.md
# Shared Interrupt Distributor with 16-bit CPU Target Maps

This block sits between the interrupt lines of a multi-core system and up to sixteen CPU interfaces. Shared peripheral lines (IDs 32 and up) are routed to any subset of CPUs through a 16-bit target map held per source. The lowest IDs belong to each CPU alone. IDs 0 to 15 are raised only by software, through a single write that names a list of target CPUs. IDs 16 to 31 come from per-CPU private lines. For every CPU the block presents one request line and the lowest eligible ID. A source is eligible when it is enabled, pending, not active and, for shared sources, aimed at that CPU.

Software programs the block over a simple 32-bit register bus. Every access carries the number of the CPU making it. That number selects the per-CPU bank of enables, pending and active state for IDs 0 to 31. A CPU takes its candidate with an acknowledge pulse, which marks the ID active. It later retires the ID with an end-of-interrupt pulse that carries the ID. A level source keeps its pending state while its line is high. An edge source latches its pending state and loses it when acknowledged.

Top module: `irq_dist`

## Requirements
- R1: Enables use separate set and clear words, at byte 0x100 + 4*(N/32) and byte 0x180 + 4*(N/32), bit N%32. Writing 1 sets or clears the bit, and writing 0 changes nothing. Reading either word returns the current enables.
- R2: Each shared source has a 16-bit CPU target map, two maps per word, at byte 0x400 + ((2*N) & ~3). The even ID uses bits [15:0] and the odd ID uses bits [31:16]. Bit c routes the source to CPU c.
- R3: For IDs 0 to 31, the enable, pending and active state is banked per CPU. The bank is chosen by `bus_cpu` for bus accesses and by the port index for acknowledge and end-of-interrupt.
- R4: Bit 0 of the control word at byte 0x000 turns forwarding on. It resets to 0. While it is 0, every `irq_o` bit is low.
- R5: Bits [4:0] of the read-only word at byte 0x004 give L, where NUM_SRC = (L+1)*32. NUM_SRC must be a multiple of 32, at least 64, and never above 510.
- R6: A write to byte 0xF00 with a CPU list in bits [23:8] and an ID in bits [3:0] makes that ID pending in the bank of every listed CPU.
- R7: The trigger word is at byte 0xC00 + 4*(N/32), bit N%32, where 1 means rising edge and 0 means active-high level; it resets to all level. Bits for IDs 0 to 15 always read 1, and writes to them are ignored.
- R8: Target maps for IDs 0 to 31 are read-only. Each half returns the one-hot bit of the accessing CPU, or 0 when `bus_cpu` is not below NUM_CPU.
- R9: A level source is pending while its sampled line is high, and acknowledging it does not clear it. An edge source latches pending on a 0-to-1 change of its line. Edge sources and IDs 0 to 15 lose pending when acknowledged.
- R10: `irq_o[c]` is high when forwarding is on and CPU c has an eligible source. `cand_id_o` for that CPU then gives the lowest eligible ID.
- R11: An acknowledge from CPU c while `irq_o[c]` is high marks its candidate active. A shared source becomes active for all CPUs, and an ID from 0 to 31 only in that CPU's bank. An end-of-interrupt clears the active mark of the ID given with it.
- R12: Read data appears on `bus_rdata` one cycle after the read is presented. Unmapped addresses, the software-interrupt word and all idle cycles give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 4 | Number of the CPU performing the access |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| shared_irq_i | input | NUM_SRC-32 | Shared source lines; bit k is ID 32+k |
| priv_irq_i | input | NUM_CPU*16 | Private lines; bit 16*c+k is ID 16+k of CPU c |
| ack_i | input | NUM_CPU | Acknowledge pulse per CPU |
| eoi_i | input | NUM_CPU | End-of-interrupt pulse per CPU |
| eoi_id_i | input | NUM_CPU*ID_W | ID retired per CPU, ID_W = clog2(NUM_SRC) |
| irq_o | output | NUM_CPU | Request line per CPU |
| cand_id_o | output | NUM_CPU*ID_W | Lowest eligible ID per CPU, 0 when its request is low |

## Verification
On every cycle, the checker confirms four things. All request lines stay low while the forwarding bit last written is 0. An acknowledged candidate never comes straight back to the same CPU. The length field, the fixed trigger bits of software IDs and the one-hot private target maps read back correctly. Unmapped reads return zero. The bench scenarios cover the behaviour that takes several steps: level sources returning after end-of-interrupt, edge latching that outlives a short pulse, independent banks for software IDs across CPUs, writes that must change nothing, and the lowest-ID choice when two routed sources compete.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
    localparam int TGT_W    = 16;
    localparam int CPU_ID_W = 4;
    localparam int MAX_SRC  = 510;

    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_TYPE = 12'h004;
    localparam logic [11:0] OFS_SWI  = 12'hF00;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_ENSET,
        RG_ENCLR,
        RG_TGT,
        RG_CFG,
        RG_SWI
    } reg_kind_e;
endpackage

// File: rtl/irq_dist_dec.sv
module irq_dist_dec
    import irq_dist_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [11:0] addr,
    output reg_kind_e   kind,
    output logic [7:0]  word
);
    localparam int NWORD = NUM_SRC / 32;
    localparam int NTGT  = NUM_SRC / 2;

    always_comb begin
        kind = RG_NONE;
        word = addr[9:2];
        if (addr[1:0] != 2'b00) begin
            kind = RG_NONE;
        end else if (addr == OFS_CTRL) begin
            kind = RG_CTRL;
        end else if (addr == OFS_TYPE) begin
            kind = RG_TYPE;
        end else if (addr == OFS_SWI) begin
            kind = RG_SWI;
        end else if (addr[11:7] == 5'b00010 && 32'(addr[6:2]) < NWORD) begin
            kind = RG_ENSET;
            word = {3'b000, addr[6:2]};
        end else if (addr[11:7] == 5'b00011 && 32'(addr[6:2]) < NWORD) begin
            kind = RG_ENCLR;
            word = {3'b000, addr[6:2]};
        end else if (addr[11:10] == 2'b01 && 32'(addr[9:2]) < NTGT) begin
            kind = RG_TGT;
            word = addr[9:2];
        end else if (addr[11:7] == 5'b11000 && 32'(addr[6:2]) < NWORD) begin
            kind = RG_CFG;
            word = {3'b000, addr[6:2]};
        end
    end
endmodule

// File: rtl/irq_dist_pick.sv
module irq_dist_pick #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  elig,
    output logic          found,
    output logic [IW-1:0] id
);
    always_comb begin
        found = |elig;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) id = IW'(i);
        end
    end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
    import irq_dist_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic [CPU_ID_W-1:0]           bus_cpu,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_SRC-33:0]           shared_irq_i,
    input  logic [NUM_CPU*16-1:0]         priv_irq_i,
    input  logic [NUM_CPU-1:0]            ack_i,
    input  logic [NUM_CPU-1:0]            eoi_i,
    input  logic [NUM_CPU*$clog2(NUM_SRC)-1:0] eoi_id_i,
    output logic [NUM_CPU-1:0]            irq_o,
    output logic [NUM_CPU*$clog2(NUM_SRC)-1:0] cand_id_o
);
    localparam int NWORD = NUM_SRC / 32;
    localparam int NSH   = NUM_SRC - 32;
    localparam int ID_W  = $clog2(NUM_SRC);

    typedef struct packed {
        logic                          fwd;
        logic [NUM_CPU-1:0][31:0]      en_b;
        logic [NUM_CPU-1:0][31:0]      pend_b;
        logic [NUM_CPU-1:0][31:0]      act_b;
        logic [NUM_CPU-1:0][15:0]      ppi_q;
        logic [15:0]                   cfg_p;
        logic [NSH-1:0]                en_s;
        logic [NSH-1:0]                pend_s;
        logic [NSH-1:0]                act_s;
        logic [NSH-1:0]                cfg_s;
        logic [NSH-1:0]                spi_q;
        logic [NSH-1:0][TGT_W-1:0]     tgt_s;
        logic [31:0]                   rdata;
    } st_t;

    st_t st_d, st_q;

    reg_kind_e                          kind;
    logic [7:0]                         word;
    logic [31:0]                        edge_b;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    elig;
    logic [NUM_CPU-1:0]                 found;
    logic [NUM_CPU-1:0][ID_W-1:0]       cand;

    irq_dist_dec #(.NUM_SRC(NUM_SRC)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .word (word)
    );

    // IDs 0..15 behave as edge (latched) sources, 16..31 follow the banked-ID trigger word.
    assign edge_b = {st_q.cfg_p, 16'hFFFF};

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            elig[c][31:0] = st_q.en_b[c] & st_q.pend_b[c] & ~st_q.act_b[c];
            for (int s = 0; s < NSH; s++) begin
                elig[c][s+32] = st_q.en_s[s] & st_q.pend_s[s] & ~st_q.act_s[s]
                              & st_q.tgt_s[s][c];
            end
        end
    end

    for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
        irq_dist_pick #(.N(NUM_SRC), .IW(ID_W)) u_pick (
            .elig  (elig[gc]),
            .found (found[gc]),
            .id    (cand[gc])
        );
        assign irq_o[gc] = st_q.fwd & found[gc];
        assign cand_id_o[gc*ID_W +: ID_W] = irq_o[gc] ? cand[gc] : '0;
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        // end of interrupt: drop the active mark
        for (int c = 0; c < NUM_CPU; c++) begin
            if (eoi_i[c]) begin
                for (int k = 0; k < 32; k++) begin
                    if (eoi_id_i[c*ID_W +: ID_W] == ID_W'(k)) st_d.act_b[c][k] = 1'b0;
                end
                for (int s = 0; s < NSH; s++) begin
                    if (eoi_id_i[c*ID_W +: ID_W] == ID_W'(s + 32)) st_d.act_s[s] = 1'b0;
                end
            end
        end

        // acknowledge: candidate becomes active, latched sources lose pending
        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_i[c] && irq_o[c]) begin
                for (int k = 0; k < 32; k++) begin
                    if (cand[c] == ID_W'(k)) begin
                        st_d.act_b[c][k] = 1'b1;
                        if (edge_b[k]) st_d.pend_b[c][k] = 1'b0;
                    end
                end
                for (int s = 0; s < NSH; s++) begin
                    if (cand[c] == ID_W'(s + 32)) begin
                        st_d.act_s[s] = 1'b1;
                        if (st_q.cfg_s[s]) st_d.pend_s[s] = 1'b0;
                    end
                end
            end
        end

        // register writes
        if (bus_valid && bus_write) begin
            case (kind)
                RG_CTRL: st_d.fwd = bus_wdata[0];
                RG_ENSET, RG_ENCLR: begin
                    if (word == 8'd0) begin
                        for (int c = 0; c < NUM_CPU; c++) begin
                            if (bus_cpu == CPU_ID_W'(c)) begin
                                if (kind == RG_ENSET) st_d.en_b[c] = st_q.en_b[c] | bus_wdata;
                                else                  st_d.en_b[c] = st_q.en_b[c] & ~bus_wdata;
                            end
                        end
                    end
                    for (int w = 1; w < NWORD; w++) begin
                        if (word == 8'(w)) begin
                            if (kind == RG_ENSET)
                                st_d.en_s[(w-1)*32 +: 32] = st_q.en_s[(w-1)*32 +: 32] | bus_wdata;
                            else
                                st_d.en_s[(w-1)*32 +: 32] = st_q.en_s[(w-1)*32 +: 32] & ~bus_wdata;
                        end
                    end
                end
                RG_TGT: begin
                    for (int s = 0; s < NSH; s++) begin
                        if (32'(word) * 2 == s + 32)     st_d.tgt_s[s] = bus_wdata[15:0];
                        if (32'(word) * 2 + 1 == s + 32) st_d.tgt_s[s] = bus_wdata[31:16];
                    end
                end
                RG_CFG: begin
                    if (word == 8'd0) st_d.cfg_p = bus_wdata[31:16];
                    for (int w = 1; w < NWORD; w++) begin
                        if (word == 8'(w)) st_d.cfg_s[(w-1)*32 +: 32] = bus_wdata;
                    end
                end
                RG_SWI: begin
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (bus_wdata[8+c]) begin
                            for (int k = 0; k < 16; k++) begin
                                if (bus_wdata[3:0] == 4'(k)) st_d.pend_b[c][k] = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end

        // register reads
        if (bus_valid && !bus_write) begin
            case (kind)
                RG_CTRL: st_d.rdata = {31'd0, st_q.fwd};
                RG_TYPE: st_d.rdata = {27'd0, 5'(NWORD - 1)};
                RG_ENSET, RG_ENCLR: begin
                    if (word == 8'd0) begin
                        for (int c = 0; c < NUM_CPU; c++) begin
                            if (bus_cpu == CPU_ID_W'(c)) st_d.rdata = st_q.en_b[c];
                        end
                    end
                    for (int w = 1; w < NWORD; w++) begin
                        if (word == 8'(w)) st_d.rdata = st_q.en_s[(w-1)*32 +: 32];
                    end
                end
                RG_TGT: begin
                    for (int h = 0; h < 2; h++) begin
                        if (32'(word) * 2 + h < 32) begin
                            for (int c = 0; c < NUM_CPU; c++) begin
                                if (bus_cpu == CPU_ID_W'(c)) st_d.rdata[h*16 +: 16] = 16'(1 << c);
                            end
                        end
                        for (int s = 0; s < NSH; s++) begin
                            if (32'(word) * 2 + h == s + 32) st_d.rdata[h*16 +: 16] = st_q.tgt_s[s];
                        end
                    end
                end
                RG_CFG: begin
                    if (word == 8'd0) st_d.rdata = edge_b;
                    for (int w = 1; w < NWORD; w++) begin
                        if (word == 8'(w)) st_d.rdata = st_q.cfg_s[(w-1)*32 +: 32];
                    end
                end
                default: st_d.rdata = '0;
            endcase
        end

        // line sampling: level follows the line, edge latches a rise
        for (int c = 0; c < NUM_CPU; c++) begin
            st_d.pend_b[c][31:16] = (st_d.pend_b[c][31:16] & st_q.cfg_p)
                                  | (priv_irq_i[c*16 +: 16] & ~st_q.cfg_p)
                                  | (st_q.cfg_p & priv_irq_i[c*16 +: 16] & ~st_q.ppi_q[c]);
            st_d.ppi_q[c] = priv_irq_i[c*16 +: 16];
        end
        st_d.pend_s = (st_d.pend_s & st_q.cfg_s)
                    | (shared_irq_i & ~st_q.cfg_s)
                    | (st_q.cfg_s & shared_irq_i & ~st_q.spi_q);
        st_d.spi_q  = shared_irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               bus_valid,
    input logic                               bus_write,
    input logic [11:0]                        bus_addr,
    input logic [31:0]                        bus_wdata,
    input logic [3:0]                         bus_cpu,
    input logic [31:0]                        bus_rdata,
    input logic [NUM_CPU-1:0]                 ack_i,
    input logic [NUM_CPU-1:0]                 irq_o,
    input logic [NUM_CPU*$clog2(NUM_SRC)-1:0] cand_id_o
);
    localparam int W = $clog2(NUM_SRC);

    logic fwd_m;
    logic rd;

    assign rd = bus_valid && !bus_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fwd_m <= 1'b0;
        else if (bus_valid && bus_write && bus_addr == 12'h000) fwd_m <= bus_wdata[0];
    end

    // R4
    fwd_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_m |-> irq_o == '0);

    // R4
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr == 12'h000 |=> bus_rdata == {31'd0, $past(fwd_m)});

    // R5
    type_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr == 12'h004 |=> bus_rdata[4:0] == 5'(NUM_SRC / 32 - 1));

    // R7
    sgi_cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr == 12'hC00 |=> bus_rdata[15:0] == 16'hFFFF);

    // R8
    priv_tgt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr[11:6] == 6'b010000 && bus_addr[1:0] == 2'b00 && 32'(bus_cpu) < NUM_CPU
        |=> bus_rdata == {2{16'd1 << $past(bus_cpu)}});

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr[11:10] == 2'b10 |=> bus_rdata == '0);

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> bus_rdata == '0);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        // R11
        ack_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack_i[c] && irq_o[c] |=> !irq_o[c] || cand_id_o[c*W +: W] != $past(cand_id_o[c*W +: W]));
    end
endmodule

bind irq_dist irq_dist_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_cpu   (bus_cpu),
    .bus_rdata (bus_rdata),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .cand_id_o (cand_id_o)
);

// File: tb/irq_dist_bench.sv
module irq_dist_bench;
    localparam int NS  = 64;
    localparam int NC  = 4;
    localparam int IW  = $clog2(NS);
    localparam int NSH = NS - 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [3:0]        bus_cpu = '0;
    logic [31:0]       bus_rdata;
    logic [NSH-1:0]    shared_irq = '0;
    logic [NC*16-1:0]  priv_irq = '0;
    logic [NC-1:0]     ack = '0;
    logic [NC-1:0]     eoi = '0;
    logic [NC*IW-1:0]  eoi_id = '0;
    logic [NC-1:0]     irq_o;
    logic [NC*IW-1:0]  cand_id_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    irq_dist #(.NUM_SRC(NS), .NUM_CPU(NC)) u_irq_dist (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_cpu      (bus_cpu),
        .bus_rdata    (bus_rdata),
        .shared_irq_i (shared_irq),
        .priv_irq_i   (priv_irq),
        .ack_i        (ack),
        .eoi_i        (eoi),
        .eoi_id_i     (eoi_id),
        .irq_o        (irq_o),
        .cand_id_o    (cand_id_o)
    );

    // monitor: read data arrives one cycle after the read
    always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R12: unexpected read data %h expected none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] cpu);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = cpu;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] cpu, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_cpu = cpu;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_spi(input int idx, input logic v);
        @(negedge clk);
        shared_irq[idx] = v;
        @(negedge clk);
    endtask

    task automatic do_ack(input int c);
        @(negedge clk);
        ack[c] = 1'b1;
        @(negedge clk);
        ack[c] = 1'b0;
    endtask

    task automatic do_eoi(input int c, input int id);
        @(negedge clk);
        eoi[c] = 1'b1;
        eoi_id[c*IW +: IW] = IW'(id);
        @(negedge clk);
        eoi[c] = 1'b0;
    endtask

    task automatic chk(input int c, input logic e_irq, input int e_id, input string t);
        logic g_irq;
        int g_id;
        g_irq = irq_o[c];
        g_id  = int'(cand_id_o[c*IW +: IW]);
        total++;
        if (g_irq !== e_irq || (e_irq && g_id != e_id)) begin
            bad++;
            $display("FAIL %s cpu%0d: irq=%0b id=%0d expected irq=%0b id=%0d",
                     t, c, g_irq, g_id, e_irq, e_id);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run incomplete expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        for (int c = 0; c < NC; c++) chk(c, 1'b0, 0, "R4 reset");
        rd(12'h000, 4'd0, 32'h0, "R4 ctrl reset");
        rd(12'h004, 4'd0, 32'h1, "R5 length field");
        rd(12'h104, 4'd0, 32'h0, "R1 enable reset");

        // R8 private target maps
        rd(12'h400, 4'd2, 32'h0004_0004, "R8 cpu2 id0/1");
        rd(12'h43C, 4'd0, 32'h0001_0001, "R8 cpu0 id30/31");
        wr(12'h400, 32'hFFFF_FFFF, 4'd2);
        rd(12'h400, 4'd2, 32'h0004_0004, "R8 write ignored");
        rd(12'h400, 4'd9, 32'h0, "R8 cpu out of range");

        // R7 trigger word 0
        rd(12'hC00, 4'd0, 32'h0000_FFFF, "R7 reset");
        wr(12'hC00, 32'h1234_0000, 4'd0);
        rd(12'hC00, 4'd0, 32'h1234_FFFF, "R7 upper writable");
        wr(12'hC00, 32'h0000_0000, 4'd0);
        rd(12'hC00, 4'd0, 32'h0000_FFFF, "R7 low fixed");

        // R1 set/clear
        wr(12'h104, 32'h5, 4'd0);
        rd(12'h104, 4'd0, 32'h5, "R1 set");
        wr(12'h184, 32'h1, 4'd0);
        rd(12'h184, 4'd0, 32'h4, "R1 clear");
        wr(12'h104, 32'h0, 4'd0);
        rd(12'h104, 4'd0, 32'h4, "R1 zero bits");
        wr(12'h104, 32'h8, 4'd0);
        rd(12'h104, 4'd0, 32'hC, "R1 set more");

        // R2 target maps for IDs 34 and 35
        wr(12'h444, 32'h0008_0002, 4'd0);
        rd(12'h444, 4'd0, 32'h0008_0002, "R2 readback");
        rd(12'h440, 4'd0, 32'h0, "R2 neighbour word");

        // R4 forwarding off hides a pending source
        set_spi(2, 1'b1);
        for (int c = 0; c < NC; c++) chk(c, 1'b0, 0, "R4 fwd off");
        wr(12'h000, 32'h1, 4'd0);
        chk(1, 1'b1, 34, "R2 routed to cpu1");
        chk(0, 1'b0, 0, "R2 not routed cpu0");
        chk(3, 1'b0, 0, "R2 not routed cpu3");

        // R10 lowest ID wins
        set_spi(3, 1'b1);
        chk(3, 1'b1, 35, "R10 single");
        wr(12'h444, 32'h0008_000A, 4'd0);
        chk(3, 1'b1, 34, "R10 lowest");
        chk(1, 1'b1, 34, "R10 cpu1");

        // R11 acknowledge / end of interrupt
        do_ack(3);
        chk(3, 1'b1, 35, "R11 active skipped");
        chk(1, 1'b0, 0, "R11 shared active");
        do_eoi(3, 34);
        chk(1, 1'b1, 34, "R9 level stays pending");
        chk(3, 1'b1, 34, "R11 eoi");

        // R9 edge latching
        set_spi(2, 1'b0);
        chk(1, 1'b0, 0, "R9 level drop");
        chk(3, 1'b1, 35, "R9 level drop cpu3");
        set_spi(3, 1'b0);
        chk(3, 1'b0, 0, "R9 level drop 35");
        wr(12'hC04, 32'h8, 4'd0);
        rd(12'hC04, 4'd0, 32'h8, "R7 shared trigger");
        @(negedge clk); shared_irq[3] = 1'b1;
        @(negedge clk); shared_irq[3] = 1'b0;
        chk(3, 1'b1, 35, "R9 edge latched");
        repeat (2) @(negedge clk);
        chk(3, 1'b1, 35, "R9 edge held");
        do_ack(3);
        chk(3, 1'b0, 0, "R9 edge ack clears");
        do_eoi(3, 35);
        chk(3, 1'b0, 0, "R9 edge gone after eoi");

        // R3 / R6 banked software IDs
        wr(12'h100, 32'h20, 4'd0);
        rd(12'h100, 4'd1, 32'h0, "R3 other bank");
        rd(12'h100, 4'd0, 32'h20, "R3 own bank");
        wr(12'hF00, 32'h0000_0305, 4'd3);
        chk(0, 1'b1, 5, "R6 swi cpu0");
        chk(1, 1'b0, 0, "R3 cpu1 not enabled");
        wr(12'h100, 32'h20, 4'd1);
        chk(1, 1'b1, 5, "R6 swi cpu1");
        do_ack(0);
        chk(0, 1'b0, 0, "R11 banked ack");
        chk(1, 1'b1, 5, "R3 bank independent");
        do_eoi(0, 5);
        chk(0, 1'b0, 0, "R9 swi cleared by ack");
        do_ack(1);
        do_eoi(1, 5);
        chk(1, 1'b0, 0, "R9 swi cpu1 cleared");

        // private line ID 20 on cpu2
        wr(12'h100, 32'h0010_0000, 4'd2);
        @(negedge clk); priv_irq[2*16 + 4] = 1'b1;
        @(negedge clk);
        chk(2, 1'b1, 20, "R3 private line");
        chk(0, 1'b0, 0, "R3 private other cpu");

        // R12 unmapped
        rd(12'h800, 4'd0, 32'h0, "R12 unmapped");
        rd(12'hF00, 4'd0, 32'h0, "R12 swi read");

        // R4 forwarding off again
        wr(12'h000, 32'h0, 4'd0);
        chk(2, 1'b0, 0, "R4 fwd cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R12: %0d reads unanswered expected 0", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule